// File: doc/BRIEF.md
# Interrupt and Trap Entry Sequencer

This block is the control sequencer that carries a small 16-bit processor into a service routine and back out again. It handles two kinds of entry. A hardware interrupt moves execution onto the supervisor stack, saves the program counter and status word there, and fetches a new program counter from the interrupt vector table. A software trap is lighter: it keeps the return address in R7 and fetches its target from a separate trap vector table. Two matching exits undo them. The interrupt return pops the saved state and switches stacks back. The trap return reloads the program counter from R7.

The processor core supplies its current PC, status word, R6 and R7. It also passes on the requests: interrupt, return-from-interrupt, trap and trap return. The sequencer performs one memory access per state through a single read/write port. The memory returns read data combinationally in the same cycle. Register updates leave the block as write-enable and data pairs. While a sequence runs, `busy` holds off instruction fetch. The block keeps the saved user and supervisor stack pointers itself.

Status word layout: bit 15 is the mode bit (1 = user, 0 = privileged). Bits 10:8 hold the running priority. Bits 2:0 hold the condition codes.

Top module: `svc_entry_seq`

## Requirements
- R1: An interrupt is accepted, and `busy` rises on the next cycle, only when all four of these hold in the same cycle while idle: `irq_req` is high, `irq_en` is high, `instr_done` is high, and `irq_prio` is strictly greater than `cur_psr[10:8]`.
- R2: On interrupt entry, the new status word has bit 15 cleared, bits 10:8 set to `irq_prio` and bits 2:0 cleared. All other bits are copied from the old status word.
- R3: On interrupt entry from user mode (`cur_psr[15]`=1), `usp_saved` takes the old R6 and the stack pointer starts at `ssp_saved`. From privileged mode, no swap is made: the stack pointer starts at the old R6 and `usp_saved` is unchanged.
- R4: Interrupt entry pre-decrements the stack pointer before each write. It writes the old PC at start-1, then the old status word at start-2. R6 ends at start-2.
- R5: The new PC after interrupt entry is the word read at `INT_BASE` + `irq_vec` (0x0100 + vector by default).
- R6: A return-from-interrupt reads the status word at R6, then the PC at R6+1, leaving the stack pointer at R6+2. If the popped status word has bit 15 set, `ssp_saved` takes R6+2 and R6 takes `usp_saved`. Otherwise R6 takes R6+2.
- R7: A trap writes the current PC into R7 and loads the PC from the word at `TRAP_BASE` + `trap_num`. It leaves R6 and the status word untouched.
- R8: A trap return loads R7 into the PC.
- R9: `busy` stays high for 3 cycles for interrupt entry, 2 for return-from-interrupt and 1 each for trap and trap return. The memory port is used only while `busy` is high.
- R10: When several requests are eligible in the same idle cycle, interrupt wins over return-from-interrupt, which wins over trap, which wins over trap return. Requests not chosen have no effect.
- R11: After reset, `busy` and `mem_req` are low, `ssp_saved` equals `SSP_INIT` and `usp_saved` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Device service request |
| irq_en | input | 1 | Device interrupt enable |
| irq_prio | input | 3 | Device priority level |
| irq_vec | input | 8 | Device vector number |
| instr_done | input | 1 | Current instruction has finished |
| trap_req | input | 1 | Trap instruction request |
| trap_num | input | 8 | Trap number |
| rti_req | input | 1 | Return-from-interrupt request |
| ret_req | input | 1 | Trap return request (PC from R7) |
| cur_pc | input | 16 | Current program counter |
| cur_psr | input | 16 | Current status word |
| cur_r6 | input | 16 | Current stack pointer register |
| cur_r7 | input | 16 | Current link register |
| busy | output | 1 | Sequence in progress, hold off fetch |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle |
| pc_we | output | 1 | PC write enable |
| pc_wdata | output | 16 | New PC |
| psr_we | output | 1 | Status word write enable |
| psr_wdata | output | 16 | New status word |
| r6_we | output | 1 | R6 write enable |
| r6_wdata | output | 16 | New R6 |
| r7_we | output | 1 | R7 write enable |
| r7_wdata | output | 16 | New R7 |
| usp_saved | output | 16 | Saved user stack pointer |
| ssp_saved | output | 16 | Saved supervisor stack pointer |

## Verification
An accepted interrupt and a trap can arrive in the same idle cycle. So can a return-from-interrupt, a trap and a trap return. The bench raises these together and judges the winner by its effects at the ports. After the interrupt wins, the PC must hold the interrupt vector and R7 must be untouched. After the return wins, the saved PC and status word must be restored and R7 must be unchanged. The acceptance rule is swept over every pairing of device and running priority, with the enable and completion inputs in all combinations and both processor modes, and each accepted entry is followed by a return.

// File: rtl/svc_seq_pkg.sv
package svc_seq_pkg;
    localparam int XLEN        = 16;
    localparam int PRIO_W      = 3;
    localparam int VEC_W       = 8;
    localparam int CC_W        = 3;
    localparam int MODE_BIT    = 15;
    localparam int PRIO_LSB    = 8;
    localparam int N_STATES    = 8;

    typedef enum logic [N_STATES-1:0] {
        ST_IDLE  = 8'b0000_0001,
        ST_IPC   = 8'b0000_0010,
        ST_IPSR  = 8'b0000_0100,
        ST_IVEC  = 8'b0000_1000,
        ST_TVEC  = 8'b0001_0000,
        ST_RPSR  = 8'b0010_0000,
        ST_RPC   = 8'b0100_0000,
        ST_RET   = 8'b1000_0000
    } seq_state_e;

    typedef struct packed {
        seq_state_e              state;
        logic [XLEN-1:0]         sp;
        logic [XLEN-1:0]         pc;
        logic [XLEN-1:0]         psr;
        logic [XLEN-1:0]         usp;
        logic [XLEN-1:0]         ssp;
        logic [VEC_W-1:0]        vec;
        logic [PRIO_W-1:0]       prio;
    } seq_regs_t;
endpackage

// File: rtl/svc_irq_gate.sv
module svc_irq_gate #(
    parameter int PW = 3
) (
    input  logic          req,
    input  logic          en,
    input  logic          done,
    input  logic [PW-1:0] dev_prio,
    input  logic [PW-1:0] run_prio,
    output logic          take
);
    always_comb begin
        take = req && en && done && (dev_prio > run_prio);
    end
endmodule

// File: rtl/svc_entry_psr.sv
module svc_entry_psr
    import svc_seq_pkg::*;
(
    input  logic [XLEN-1:0]   old_psr,
    input  logic [PRIO_W-1:0] dev_prio,
    output logic [XLEN-1:0]   new_psr
);
    always_comb begin
        new_psr                          = old_psr;
        new_psr[MODE_BIT]                = 1'b0;
        new_psr[PRIO_LSB +: PRIO_W]      = dev_prio;
        new_psr[CC_W-1:0]                = '0;
    end
endmodule

// File: rtl/svc_stack_sel.sv
module svc_stack_sel
    import svc_seq_pkg::*;
(
    input  logic            ent_user,
    input  logic [XLEN-1:0] ent_r6,
    input  logic [XLEN-1:0] ssp_q,
    input  logic [XLEN-1:0] usp_q,
    output logic [XLEN-1:0] ent_sp,
    output logic [XLEN-1:0] ent_usp,
    input  logic            ext_user,
    input  logic [XLEN-1:0] ext_sp,
    output logic [XLEN-1:0] ext_r6,
    output logic [XLEN-1:0] ext_ssp
);
    always_comb begin
        if (ent_user) begin
            ent_sp  = ssp_q;
            ent_usp = ent_r6;
        end else begin
            ent_sp  = ent_r6;
            ent_usp = usp_q;
        end
        if (ext_user) begin
            ext_r6  = usp_q;
            ext_ssp = ext_sp;
        end else begin
            ext_r6  = ext_sp;
            ext_ssp = ssp_q;
        end
    end
endmodule

// File: rtl/svc_entry_seq.sv
module svc_entry_seq
    import svc_seq_pkg::*;
#(
    parameter logic [15:0] SSP_INIT  = 16'h3000,
    parameter logic [15:0] INT_BASE  = 16'h0100,
    parameter logic [15:0] TRAP_BASE = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic              irq_en,
    input  logic [2:0]        irq_prio,
    input  logic [7:0]        irq_vec,
    input  logic              instr_done,
    input  logic              trap_req,
    input  logic [7:0]        trap_num,
    input  logic              rti_req,
    input  logic              ret_req,
    input  logic [15:0]       cur_pc,
    input  logic [15:0]       cur_psr,
    input  logic [15:0]       cur_r6,
    input  logic [15:0]       cur_r7,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [15:0]       mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic              pc_we,
    output logic [15:0]       pc_wdata,
    output logic              psr_we,
    output logic [15:0]       psr_wdata,
    output logic              r6_we,
    output logic [15:0]       r6_wdata,
    output logic              r7_we,
    output logic [15:0]       r7_wdata,
    output logic [15:0]       usp_saved,
    output logic [15:0]       ssp_saved
);
    localparam logic [XLEN-1:0] ONE = XLEN'(1);

    seq_regs_t r_q, r_d;

    logic            irq_take;
    logic [XLEN-1:0] ent_sp, ent_usp, ext_r6, ext_ssp, ext_sp;
    logic [XLEN-1:0] entry_psr;

    svc_irq_gate #(.PW(PRIO_W)) gate_i (
        .req      (irq_req),
        .en       (irq_en),
        .done     (instr_done),
        .dev_prio (irq_prio),
        .run_prio (cur_psr[PRIO_LSB +: PRIO_W]),
        .take     (irq_take)
    );

    svc_entry_psr psr_i (
        .old_psr  (r_q.psr),
        .dev_prio (r_q.prio),
        .new_psr  (entry_psr)
    );

    assign ext_sp = r_q.sp + ONE;

    svc_stack_sel stk_i (
        .ent_user (cur_psr[MODE_BIT]),
        .ent_r6   (cur_r6),
        .ssp_q    (r_q.ssp),
        .usp_q    (r_q.usp),
        .ent_sp   (ent_sp),
        .ent_usp  (ent_usp),
        .ext_user (r_q.psr[MODE_BIT]),
        .ext_sp   (ext_sp),
        .ext_r6   (ext_r6),
        .ext_ssp  (ext_ssp)
    );

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        pc_we     = 1'b0;
        pc_wdata  = '0;
        psr_we    = 1'b0;
        psr_wdata = '0;
        r6_we     = 1'b0;
        r6_wdata  = '0;
        r7_we     = 1'b0;
        r7_wdata  = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (irq_take) begin
                    r_d.pc    = cur_pc;
                    r_d.psr   = cur_psr;
                    r_d.sp    = ent_sp;
                    r_d.usp   = ent_usp;
                    r_d.vec   = irq_vec;
                    r_d.prio  = irq_prio;
                    r_d.state = ST_IPC;
                end else if (rti_req) begin
                    r_d.sp    = cur_r6;
                    r_d.state = ST_RPSR;
                end else if (trap_req) begin
                    r_d.pc    = cur_pc;
                    r_d.vec   = trap_num;
                    r_d.state = ST_TVEC;
                end else if (ret_req) begin
                    r_d.state = ST_RET;
                end
            end
            ST_IPC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - ONE;
                mem_wdata = r_q.pc;
                r_d.sp    = r_q.sp - ONE;
                r_d.state = ST_IPSR;
            end
            ST_IPSR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - ONE;
                mem_wdata = r_q.psr;
                r_d.sp    = r_q.sp - ONE;
                r_d.state = ST_IVEC;
            end
            ST_IVEC: begin
                mem_req   = 1'b1;
                mem_addr  = INT_BASE + XLEN'(r_q.vec);
                pc_we     = 1'b1;
                pc_wdata  = mem_rdata;
                psr_we    = 1'b1;
                psr_wdata = entry_psr;
                r6_we     = 1'b1;
                r6_wdata  = r_q.sp;
                r_d.state = ST_IDLE;
            end
            ST_TVEC: begin
                mem_req   = 1'b1;
                mem_addr  = TRAP_BASE + XLEN'(r_q.vec);
                pc_we     = 1'b1;
                pc_wdata  = mem_rdata;
                r7_we     = 1'b1;
                r7_wdata  = r_q.pc;
                r_d.state = ST_IDLE;
            end
            ST_RPSR: begin
                mem_req   = 1'b1;
                mem_addr  = r_q.sp;
                r_d.psr   = mem_rdata;
                r_d.sp    = r_q.sp + ONE;
                r_d.state = ST_RPC;
            end
            ST_RPC: begin
                mem_req   = 1'b1;
                mem_addr  = r_q.sp;
                pc_we     = 1'b1;
                pc_wdata  = mem_rdata;
                psr_we    = 1'b1;
                psr_wdata = r_q.psr;
                r6_we     = 1'b1;
                r6_wdata  = ext_r6;
                r_d.ssp   = ext_ssp;
                r_d.sp    = ext_sp;
                r_d.state = ST_IDLE;
            end
            ST_RET: begin
                pc_we     = 1'b1;
                pc_wdata  = cur_r7;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.sp    <= '0;
            r_q.pc    <= '0;
            r_q.psr   <= '0;
            r_q.usp   <= '0;
            r_q.ssp   <= SSP_INIT;
            r_q.vec   <= '0;
            r_q.prio  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.state != ST_IDLE);
    assign usp_saved = r_q.usp;
    assign ssp_saved = r_q.ssp;

    // R9: exactly one state flag set
    p_onehot_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(r_q.state) == 1);

    // R9: memory only used while busy
    p_mem_in_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R1: entry only after a qualifying request
    p_accept_cond_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IPC) |->
        $past(irq_req && irq_en && instr_done &&
              (irq_prio > cur_psr[PRIO_LSB +: PRIO_W])));

    // R2: entry status word is privileged with clear condition codes
    p_entry_psr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IVEC) |-> (psr_we && !psr_wdata[MODE_BIT] && psr_wdata[CC_W-1:0] == '0));

    // R4: second push lands one word below the first
    p_push_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IPSR) |-> (mem_we && mem_addr == $past(mem_addr) - ONE));

    // R5: vector fetch stays inside the interrupt table
    p_ivec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IVEC) |-> (mem_req && !mem_we && mem_addr >= INT_BASE &&
                                    mem_addr < INT_BASE + 16'd256));

    // R7: trap links through R7 without touching memory by write
    p_trap_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_TVEC) |-> (r7_we && !mem_we && !r6_we && !psr_we));

    // R11: idle means no side effects
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !pc_we && !psr_we && !r6_we && !r7_we));
endmodule

// File: tb/svc_entry_seq_tb.sv
module svc_entry_seq_tb_top;
    localparam logic [15:0] SSP0 = 16'h0800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic irq_req = 0, irq_en = 0, instr_done = 0, trap_req = 0, rti_req = 0, ret_req = 0;
    logic [2:0] irq_prio = 0;
    logic [7:0] irq_vec = 0, trap_num = 0;
    logic busy, mem_req, mem_we, pc_we, psr_we, r6_we, r7_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, pc_wdata, psr_wdata, r6_wdata, r7_wdata;
    logic [15:0] usp_saved, ssp_saved;

    logic [15:0] pc_r = 0, psr_r = 0, r6_r = 0, r7_r = 0;
    logic        ld = 0;
    logic [15:0] ld_pc = 0, ld_psr = 0, ld_r6 = 0, ld_r7 = 0;
    logic [15:0] ram [0:4095];

    int n_chk = 0, n_fail = 0, cyc = 0;

    svc_entry_seq #(.SSP_INIT(SSP0)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en), .irq_prio(irq_prio),
        .irq_vec(irq_vec), .instr_done(instr_done), .trap_req(trap_req), .trap_num(trap_num),
        .rti_req(rti_req), .ret_req(ret_req), .cur_pc(pc_r), .cur_psr(psr_r), .cur_r6(r6_r),
        .cur_r7(r7_r), .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_we(pc_we), .pc_wdata(pc_wdata),
        .psr_we(psr_we), .psr_wdata(psr_wdata), .r6_we(r6_we), .r6_wdata(r6_wdata),
        .r7_we(r7_we), .r7_wdata(r7_wdata), .usp_saved(usp_saved), .ssp_saved(ssp_saved)
    );

    function automatic logic [15:0] tbl(input logic [15:0] a);
        if (a >= 16'h0100 && a < 16'h0200) return 16'h4000 + (a - 16'h0100) * 16'd3;
        if (a < 16'h0100) return 16'h2000 + a * 16'd5;
        return ram[a[11:0]];
    endfunction
    assign mem_rdata = tbl(mem_addr);

    always @(posedge clk) begin
        if (mem_req && mem_we) ram[mem_addr[11:0]] <= mem_wdata;
        if (ld) begin
            pc_r <= ld_pc; psr_r <= ld_psr; r6_r <= ld_r6; r7_r <= ld_r7;
        end else begin
            if (pc_we)  pc_r  <= pc_wdata;
            if (psr_we) psr_r <= psr_wdata;
            if (r6_we)  r6_r  <= r6_wdata;
            if (r7_we)  r7_r  <= r7_wdata;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk = n_chk + 1; n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] p, input logic [15:0] s, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        ld = 1; ld_pc = p; ld_psr = s; ld_r6 = a; ld_r7 = b;
        @(posedge clk);
        @(negedge clk);
        ld = 0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 20) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_rti(output int n);
        @(negedge clk); rti_req = 1;
        @(posedge clk); @(negedge clk); rti_req = 0;
        wait_idle(n);
    endtask

    initial begin
        int nb;
        logic [15:0] usp_exp;
        usp_exp = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk(!busy, "R11 busy after reset", 16'(busy), 16'h0);
        chk(!mem_req, "R11 mem_req after reset", 16'(mem_req), 16'h0);
        chk(ssp_saved == SSP0, "R11 ssp_saved", ssp_saved, SSP0);
        chk(usp_saved == 16'h0, "R11 usp_saved", usp_saved, 16'h0);
        rst_n = 1;

        // R1..R6, R9: sweep acceptance and full entry/return
        for (int en = 0; en < 2; en++)
          for (int dn = 0; dn < 2; dn++)
            for (int dp = 0; dp < 8; dp++)
              for (int rp = 0; rp < 8; rp++) begin
                logic user, take;
                logic [15:0] pc0, psr0, r60, sp0, exp_psr;
                logic [7:0] v;
                user = ~rp[1];
                v    = 8'(dp * 32 + rp * 4 + en * 2 + dn);
                pc0  = 16'h3000 + 16'(v);
                psr0 = {user, 4'b1010, 3'(rp), 5'b10110, 3'b101};
                r60  = user ? 16'h0F00 : 16'h0700;
                take = en[0] && dn[0] && (dp > rp);
                load(pc0, psr0, r60, 16'h1234);
                irq_req = 1; irq_en = en[0]; instr_done = dn[0]; irq_prio = 3'(dp); irq_vec = v;
                @(posedge clk); @(negedge clk);
                irq_req = 0; irq_en = 0; instr_done = 0;
                chk(busy == take, "R1 acceptance", 16'(busy), 16'(take));
                if (!take) begin
                    @(negedge clk);
                    chk(pc_r == pc0 && r6_r == r60, "R1 no effect when refused", pc_r, pc0);
                end else begin
                    wait_idle(nb);
                    chk(nb == 3, "R9 interrupt busy cycles", 16'(nb), 16'd3);
                    chk(pc_r == 16'h4000 + 16'(v) * 16'd3, "R5 vector PC", pc_r, 16'h4000 + 16'(v) * 16'd3);
                    exp_psr = {1'b0, 4'b1010, 3'(dp), 5'b10110, 3'b000};
                    chk(psr_r == exp_psr, "R2 entry psr", psr_r, exp_psr);
                    sp0 = user ? SSP0 : r60;
                    if (user) usp_exp = r60;
                    chk(r6_r == sp0 - 16'd2, "R3 R4 stack pointer", r6_r, sp0 - 16'd2);
                    chk(usp_saved == usp_exp, "R3 saved user sp", usp_saved, usp_exp);
                    chk(ram[12'(sp0 - 16'd1)] == pc0, "R4 pushed pc", ram[12'(sp0 - 16'd1)], pc0);
                    chk(ram[12'(sp0 - 16'd2)] == psr0, "R4 pushed psr", ram[12'(sp0 - 16'd2)], psr0);
                    pulse_rti(nb);
                    chk(nb == 2, "R9 return busy cycles", 16'(nb), 16'd2);
                    chk(pc_r == pc0, "R6 restored pc", pc_r, pc0);
                    chk(psr_r == psr0, "R6 restored psr", psr_r, psr0);
                    chk(r6_r == r60, "R6 restored r6", r6_r, r60);
                    chk(ssp_saved == SSP0, "R6 ssp_saved", ssp_saved, SSP0);
                end
              end

        // R7: trap sweep
        for (int t = 0; t < 256; t++) begin
            logic [15:0] pc0;
            pc0 = 16'h3100 + 16'(t);
            load(pc0, 16'h8000, 16'h0F00, 16'h0000);
            trap_req = 1; trap_num = 8'(t);
            @(posedge clk); @(negedge clk);
            trap_req = 0;
            wait_idle(nb);
            chk(nb == 1, "R9 trap busy cycles", 16'(nb), 16'd1);
            chk(r7_r == pc0, "R7 link", r7_r, pc0);
            chk(pc_r == 16'h2000 + 16'(t) * 16'd5, "R7 trap PC", pc_r, 16'h2000 + 16'(t) * 16'd5);
            chk(r6_r == 16'h0F00 && psr_r == 16'h8000, "R7 r6 psr kept", r6_r, 16'h0F00);
        end

        // R8: trap return
        load(16'h2222, 16'h8000, 16'h0F00, 16'h5A5A);
        ret_req = 1;
        @(posedge clk); @(negedge clk);
        ret_req = 0;
        wait_idle(nb);
        chk(nb == 1, "R9 ret busy cycles", 16'(nb), 16'd1);
        chk(pc_r == 16'h5A5A, "R8 pc from r7", pc_r, 16'h5A5A);

        // R10: interrupt and trap together
        load(16'h3333, 16'h8000, 16'h0F00, 16'h7777);
        irq_req = 1; irq_en = 1; instr_done = 1; irq_prio = 3'd4; irq_vec = 8'h10;
        trap_req = 1; trap_num = 8'h21; ret_req = 1;
        @(posedge clk); @(negedge clk);
        irq_req = 0; trap_req = 0; ret_req = 0;
        wait_idle(nb);
        chk(pc_r == 16'h4030, "R10 interrupt wins over trap", pc_r, 16'h4030);
        chk(r7_r == 16'h7777, "R10 trap ignored", r7_r, 16'h7777);
        // R10: return wins over trap and trap return
        @(negedge clk); rti_req = 1; trap_req = 1; ret_req = 1;
        @(posedge clk); @(negedge clk);
        rti_req = 0; trap_req = 0; ret_req = 0;
        wait_idle(nb);
        chk(pc_r == 16'h3333, "R10 return wins pc", pc_r, 16'h3333);
        chk(r7_r == 16'h7777, "R10 r7 untouched", r7_r, 16'h7777);
        chk(r6_r == 16'h0F00, "R10 r6 restored", r6_r, 16'h0F00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule